// File: doc/BRIEF.md
# Tone-Pair Guard-Time Steering Validator

This block sits between a dual-tone frequency detector and the receive status logic of a signalling receiver. The detector supplies a raw flag that is high while a valid tone pair is heard and drops at once on any loss of the pair, together with the 4-bit code of that pair. The block replaces an analogue RC steering network with two clock-tick counters. One counter confirms that the pair has been present for long enough. The other confirms that the pair has been absent for long enough. Together they reject short bursts and ride through short dropouts.

When presence is confirmed, the block registers the current code in its receive latch. A fixed number of cycles later it drives the delayed-steering flag low and emits a one-cycle new-data pulse, which the status logic uses to set its receive-register-full bit. When absence is confirmed, the flag returns high after the same settle delay. The latched code is kept until the next pair is registered. Both guard times are register inputs counted in clock cycles. The settle delay is a build parameter.

Top module: `tone_steer_validator`

## Requirements
- R1: After a clock edge with rst_n low, rx_code is 0, steer_n is 1 and rx_new is 0.
- R2: In the absent state, rx_code takes the value of pair_code sampled at the edge where pair_present has been high for G consecutive edges, with G = max(present_guard, 1). A burst shorter than G leaves rx_code and steer_n unchanged.
- R3: steer_n goes low exactly SETTLE_CYC edges after the edge that latched the code, so the code is visible before the flag asserts.
- R4: rx_new is high for exactly one cycle, the first cycle in which steer_n is low after being high.
- R5: While the pair stays confirmed, rx_code does not follow changes on pair_code.
- R6: In the confirmed state, the state is released at the edge where pair_present has been low for A consecutive edges, with A = max(absent_guard, 1). steer_n returns to 1 exactly SETTLE_CYC edges after that edge.
- R7: A dropout of fewer than A low samples has no effect: steer_n stays 0, rx_code is unchanged and rx_new stays 0.
- R8: After release, rx_code keeps the last registered digit until the next pair is registered.
- R9: A guard value of 0 acts as 1, so a single sampled edge confirms presence or absence.
- R10: Any sample in the opposite state restarts a guard count from zero, so two partial bursts split by one low sample never register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pair_present | input | 1 | Raw flag from the detector: a valid tone pair is heard |
| pair_code | input | CODE_W | Code of the pair currently heard |
| present_guard | input | CNT_W | Presence guard time in clock cycles |
| absent_guard | input | CNT_W | Absence guard time in clock cycles |
| rx_code | output | CODE_W | Last registered code |
| steer_n | output | 1 | Delayed steering flag: 0 while a pair is confirmed, 1 otherwise |
| rx_new | output | 1 | One-cycle pulse when a newly registered code becomes valid |

## Verification
Two events can fall in the same cycle. The first is a fresh code latch at a validation edge. The second is the flag edge, or the new-data pulse, of an earlier validation that is still travelling through the settle delay. This overlap arises when guards of 0 to 2 cycles are combined with bursts and gaps shorter than the settle delay. The bench provokes it with constrained random bursts whose guards are re-drawn for every burst, and with a directed case that uses zero guards. Each cycle, the bench compares all three outputs against a bench-side model of the requirements. It therefore judges whether the latch and the delayed flag stay separately correct when they coincide.

// File: rtl/steer_pkg.sv
// Package: shared types for the tone-pair steering validator.
// Assumes nothing beyond a single clock domain.
package steer_pkg;

    // Confirmed-state encoding of the steering core.
    typedef enum logic {
        ST_ABSENT  = 1'b0,
        ST_PRESENT = 1'b1
    } steer_state_e;

endpackage

// File: rtl/guard_timer.sv
// guard_timer: counts consecutive cycles in which `run` is high and
// flags `expire` combinationally on the cycle whose edge completes the
// guard. A guard of 0 acts as 1. Dropping `run` clears the count.
// Assumes the guard value may change at any time; a guard lowered below
// the current count expires at once.
module guard_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] guard,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W-1:0] guard_eff;

    // Effective guard and completion test for this sample.
    always_comb begin
        guard_eff = (guard == '0) ? CNT_W'(1) : guard;
        cnt_inc   = {1'b0, cnt_q} + (CNT_W+1)'(1);
        expire    = run && (cnt_inc >= {1'b0, guard_eff});
    end

    // Consecutive-sample counter, restarted on interruption or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/steer_core.sv
// steer_core: hysteretic confirmed-state machine with two guard timers.
// The presence timer runs only in the absent state; the absence timer runs
// only in the confirmed state. The code latch loads at the edge that
// confirms presence. Assumes pair_present is already synchronous to clk.
module steer_core
    import steer_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_present,
    input  logic [CODE_W-1:0] pair_code,
    input  logic [CNT_W-1:0]  present_guard,
    input  logic [CNT_W-1:0]  absent_guard,
    output steer_state_e      state_q,
    output logic [CODE_W-1:0] code_q
);
    logic run_present;
    logic run_absent;
    logic present_done;
    logic absent_done;

    // Timer enables: each counts the condition that would leave the state.
    always_comb begin
        run_present = pair_present  && (state_q == ST_ABSENT);
        run_absent  = !pair_present && (state_q == ST_PRESENT);
    end

    guard_timer #(.CNT_W(CNT_W)) present_tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_present),
        .guard  (present_guard),
        .expire (present_done)
    );

    guard_timer #(.CNT_W(CNT_W)) absent_tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_absent),
        .guard  (absent_guard),
        .expire (absent_done)
    );

    // Confirmed-state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ABSENT;
        end else if (present_done) begin
            state_q <= ST_PRESENT;
        end else if (absent_done) begin
            state_q <= ST_ABSENT;
        end
    end

    // Receive code latch, loaded only on confirmation of presence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (present_done) begin
            code_q <= pair_code;
        end
    end
endmodule

// File: rtl/settle_delay.sv
// settle_delay: delays the confirmed state by STAGES cycles to form the
// active-low steering flag, and derives a one-cycle pulse on the first
// cycle the delayed flag asserts. Assumes STAGES >= 1.
module settle_delay #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_in,
    output logic steer_n,
    output logic new_pulse
);
    logic [STAGES-1:0] stage_q;
    logic              hold_q;

    generate
        if (STAGES == 1) begin : g_single
            // One-stage delay of the confirmed state.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= valid_in;
            end
        end else begin : g_chain
            // Multi-stage shift of the confirmed state.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[STAGES-2:0], valid_in};
            end
        end
    endgenerate

    // Previous value of the delayed state, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= stage_q[STAGES-1];
    end

    // Outputs of the delay line.
    always_comb begin
        steer_n   = !stage_q[STAGES-1];
        new_pulse = stage_q[STAGES-1] && !hold_q;
    end
endmodule

// File: rtl/tone_steer_validator_chk.sv
// tone_steer_validator_chk: property checker bound to the top module.
// Observes ports plus the confirmed-state bit of the steering core.
module tone_steer_validator_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pair_present,
    input logic [CODE_W-1:0] pair_code,
    input logic [CODE_W-1:0] rx_code,
    input logic              steer_n,
    input logic              rx_new,
    input logic              held
);
    // R2: confirmation only follows a presence sample, and latches that code.
    a_r2_rise_needs_presence: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> $past(pair_present));
    a_r2_latch_code: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> (rx_code == $past(pair_code)));
    // R4: the pulse is single-cycle and coincides with an asserted flag.
    a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_new |=> !rx_new);
    a_r4_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rx_new |-> !steer_n);
    // R5: code is stable while confirmed.
    a_r5_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (held && $past(held)) |-> $stable(rx_code));
    // R6: release only follows an absence sample.
    a_r6_release_needs_absence: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(held) |-> !$past(pair_present));
endmodule

// File: rtl/tone_steer_validator.sv
// tone_steer_validator: guard-time steering for a tone-pair receiver.
// Confirms presence and absence of a raw pair flag with two cycle-count
// guards, latches the code on confirmation and, SETTLE_CYC cycles later,
// drives the active-low steering flag and a one-cycle new-data pulse.
// Assumes inputs are synchronous to clk; guards are in clock cycles.
module tone_steer_validator
    import steer_pkg::*;
#(
    parameter int CODE_W     = 4,
    parameter int CNT_W      = 16,
    parameter int SETTLE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_present,
    input  logic [CODE_W-1:0] pair_code,
    input  logic [CNT_W-1:0]  present_guard,
    input  logic [CNT_W-1:0]  absent_guard,
    output logic [CODE_W-1:0] rx_code,
    output logic              steer_n,
    output logic              rx_new
);
    localparam int STAGES = (SETTLE_CYC < 1) ? 1 : SETTLE_CYC;

    steer_state_e core_state;
    logic         tone_held;

    steer_core #(.CODE_W(CODE_W), .CNT_W(CNT_W)) core_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .pair_present  (pair_present),
        .pair_code     (pair_code),
        .present_guard (present_guard),
        .absent_guard  (absent_guard),
        .state_q       (core_state),
        .code_q        (rx_code)
    );

    // Confirmed-state bit fed to the settle delay.
    always_comb tone_held = (core_state == ST_PRESENT);

    settle_delay #(.STAGES(STAGES)) settle_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (tone_held),
        .steer_n   (steer_n),
        .new_pulse (rx_new)
    );
endmodule

bind tone_steer_validator tone_steer_validator_chk #(.CODE_W(CODE_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pair_present (pair_present),
    .pair_code    (pair_code),
    .rx_code      (rx_code),
    .steer_n      (steer_n),
    .rx_new       (rx_new),
    .held         (tone_held)
);

// File: tb/tone_steer_validator_tb_top.sv
// Bench: directed corner cases plus seeded random bursts, checked each
// cycle against a bench model built from the requirements.
module tone_steer_validator_tb_top;
    localparam int CW = 4;
    localparam int NW = 16;
    localparam int S  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pp = 1'b0;
    logic [CW-1:0] pc = '0;
    logic [NW-1:0] pg = 16'd6;
    logic [NW-1:0] ag = 16'd4;
    logic [CW-1:0] rx_code;
    logic          steer_n;
    logic          rx_new;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    tone_steer_validator #(.CODE_W(CW), .CNT_W(NW), .SETTLE_CYC(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .pair_present(pp), .pair_code(pc),
        .present_guard(pg), .absent_guard(ag),
        .rx_code(rx_code), .steer_n(steer_n), .rx_new(rx_new)
    );

    always #5 clk = ~clk;

    // Bench model state.
    bit            m_v;
    int            m_cnt;
    logic [CW-1:0] m_code;
    bit            m_chain [0:S];
    bit            m_hold;
    bit            m_latched;

    function automatic int eff(input logic [NW-1:0] g);
        return (g == 0) ? 1 : int'(g);
    endfunction

    // Model update from the requirements, on the same edges as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_v = 0; m_cnt = 0; m_code = '0; m_hold = 0; m_latched = 0;
            for (int i = 0; i <= S; i++) m_chain[i] = 0;
        end else begin
            m_hold = m_chain[S];
            for (int i = S; i > 0; i--) m_chain[i] = m_chain[i-1];
            m_latched = 0;
            if (!m_v) begin
                if (pp) begin
                    if (m_cnt + 1 >= eff(pg)) begin
                        m_v = 1; m_cnt = 0; m_code = pc; m_latched = 1;
                    end else m_cnt++;
                end else m_cnt = 0;
            end else begin
                if (!pp) begin
                    if (m_cnt + 1 >= eff(ag)) begin
                        m_v = 0; m_cnt = 0;
                    end else m_cnt++;
                end else m_cnt = 0;
            end
            m_chain[0] = m_v;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string ctag;
            if (m_latched) ctag = "R2";
            else if (m_v)  ctag = "R5";
            else           ctag = "R8";
            check(rx_code == m_code, ctag, "rx_code", rx_code, m_code);
            check(steer_n == !m_chain[S], m_chain[S] ? "R3" : "R6", "steer_n",
                  steer_n, !m_chain[S]);
            check(rx_new == (m_chain[S] && !m_hold), "R4", "rx_new",
                  rx_new, m_chain[S] && !m_hold);
        end
    end

    task automatic hold(input bit p, input logic [CW-1:0] c, input int n);
        pp = p; pc = c;
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240917);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // r1_ reset state
        check(rx_code == 0 && steer_n && !rx_new, "R1", "reset outputs",
              {rx_code, steer_n, rx_new}, 2);

        pg = 6; ag = 4;
        // R2: a burst one short of the guard is rejected.
        hold(1, 4'd5, 5); hold(0, 4'd5, 10);
        check(steer_n == 1, "R2", "short burst steer_n", steer_n, 1);
        check(rx_code == 0, "R2", "short burst rx_code", rx_code, 0);

        // R2/R3: a full burst latches the code before the flag.
        hold(1, 4'd7, 6);
        check(rx_code == 7, "R2", "latched code", rx_code, 7);
        check(steer_n == 1, "R3", "flag not yet asserted", steer_n, 1);
        hold(1, 4'd7, S);
        check(steer_n == 0, "R3", "flag after settle", steer_n, 0);
        check(rx_new == 1, "R4", "new-data pulse", rx_new, 1);
        hold(1, 4'd9, 1);
        check(rx_new == 0, "R4", "pulse ends", rx_new, 0);
        hold(1, 4'd9, 9);
        check(rx_code == 7, "R5", "code held while confirmed", rx_code, 7);

        // R7: dropout one short of the absent guard is ignored.
        hold(0, 4'd9, 3); hold(1, 4'd9, 5);
        check(steer_n == 0, "R7", "dropout steer_n", steer_n, 0);
        check(rx_code == 7, "R7", "dropout rx_code", rx_code, 7);

        // R6: release after the absent guard plus the settle delay.
        hold(0, 4'd9, 4 + S - 1);
        check(steer_n == 0, "R6", "flag before settle", steer_n, 0);
        hold(0, 4'd9, 1);
        check(steer_n == 1, "R6", "flag released", steer_n, 1);

        // R8: code kept through absence.
        hold(0, 4'd3, 20);
        check(rx_code == 7, "R8", "code kept after release", rx_code, 7);

        // R10: two partial bursts split by one low sample never register.
        hold(1, 4'd2, 5); hold(0, 4'd2, 1); hold(1, 4'd2, 5); hold(0, 4'd2, 10);
        check(steer_n == 1, "R10", "split burst steer_n", steer_n, 1);
        check(rx_code == 7, "R10", "split burst rx_code", rx_code, 7);

        // R9: zero guards act as one cycle.
        pg = 0; ag = 0;
        hold(1, 4'hB, 1);
        check(rx_code == 4'hB, "R9", "zero present guard", rx_code, 11);
        hold(0, 4'hB, S + 2);
        check(steer_n == 1, "R9", "zero absent guard", steer_n, 1);

        // Random bursts, gaps and guards (overlap of latch and settle).
        for (int it = 0; it < 400; it++) begin
            int blen, glen;
            logic [CW-1:0] c;
            pg = NW'($urandom_range(0, 12));
            ag = NW'($urandom_range(0, 10));
            blen = $urandom_range(1, 20);
            glen = $urandom_range(1, 15);
            c = CW'($urandom_range(0, 15));
            for (int k = 0; k < blen; k++) begin
                if ($urandom_range(0, 9) == 0) c = CW'($urandom_range(0, 15));
                hold(1, c, 1);
            end
            hold(0, c, glen);
        end
        hold(0, 4'd0, 30);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule